// File: doc/BRIEF.md
# Sleep Mode Power Controller

This block decides when a small processor core may sleep, which clock domains stay alive while it sleeps, and how it comes back. Software sets a sleep-enable bit and a three-bit mode code in an 8-bit control register. The core then pulses a sleep strobe when it executes its sleep instruction. The core enters sleep only if the enable bit is set at that moment.

While asleep, the block drives five clock-run enables: CPU, I/O, ADC, asynchronous timer and main oscillator. Their values follow the latched mode. A wake can come from an enabled interrupt or from a reset request. On a wake, the block holds the core halted through a start-up count and then four more cycles. It then pulses either an interrupt-service strobe or a restart-from-reset-vector strobe for one cycle. It never clears core state on an interrupt wake.

The start-up counts are inputs. The short count applies to modes that keep the oscillator running. The full count applies to modes that stop it. A separate flag tells the block whether an external crystal is fitted, because the standby modes need one.

Top module: `slp_pwr_ctrl`

## Requirements
- R1: After reset the control register reads 0x00. Every one of its 8 bits can be written and read back unchanged on `reg_rdata` in the cycle after the write.
- R2: A `sleep_strobe` is accepted only while control bit 5 (sleep enable) is 1. With bit 5 at 0, the strobe leaves `core_halt` at 0 and every clock enable at 1.
- R3: The mode code is {bit2, bit4, bit3} of the control register, read as {m2,m1,m0}. Codes: 000 idle, 001 ADC quiet, 010 deep off, 011 timer-only, 100/101 reserved, 110 standby, 111 standby plus timer.
- R4: While asleep the enables {cpu,io,adc,async,osc} are as follows. Idle: 01111. ADC quiet: 00111. Deep off: 00000. Timer-only: 00010. Standby: 00001. Standby plus timer: 00011. Here 1 means the clock runs.
- R5: The reserved codes 100 and 101 give the idle enables and the idle start-up count.
- R6: Codes 110 and 111 with `xtal_sel` at 0 give the idle enables and the idle start-up count.
- R7: An interrupt wake keeps `core_halt` at 1 for the start-up count plus 4 cycles after the wake edge. Then `wake_irq` is 1 for exactly one cycle, with `core_halt` at 0 in that cycle.
- R8: The start-up count is `startup_full` for deep off and timer-only, and `startup_short` for every other effective mode.
- R9: A reset request while asleep, or during the wake sequence, ends the sequence with a one-cycle `wake_reset` instead of `wake_irq`. It takes priority over a simultaneous interrupt.
- R10: An interrupt wake never raises `wake_reset`. The two wake pulses are never high together.
- R11: Whenever `core_halt` is 0, all five clock enables are 1.
- R12: During the start-up count `osc_en` is 1 and `clk_en_cpu` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Control register write strobe |
| reg_wdata | input | 8 | Control register write data |
| reg_rdata | output | 8 | Control register contents |
| sleep_strobe | input | 1 | One-cycle pulse from the core's sleep instruction |
| irq_pending | input | 1 | An enabled interrupt is pending |
| rst_req | input | 1 | Reset request from a reset source |
| xtal_sel | input | 1 | External crystal or resonator fitted |
| startup_short | input | 8 | Start-up cycles when the oscillator stayed on |
| startup_full | input | 8 | Start-up cycles when the oscillator was stopped |
| core_halt | output | 1 | Core must not execute |
| clk_en_cpu | output | 1 | CPU clock runs |
| clk_en_io | output | 1 | I/O clock runs |
| clk_en_adc | output | 1 | ADC clock runs |
| clk_en_async | output | 1 | Asynchronous timer clock runs |
| osc_en | output | 1 | Main oscillator runs |
| wake_irq | output | 1 | One-cycle pulse: resume and service the interrupt |
| wake_reset | output | 1 | One-cycle pulse: restart from the reset vector |

## Verification
The in-line properties check on every cycle that the two wake pulses are exclusive and last one cycle, and that a wake pulse always follows a halted cycle. They also check that the CPU clock is off while halted, that all clocks run when not halted, and that the oscillator runs during start-up. They further check that a strobe with the enable bit clear causes no halt, and that the register is zero after reset. Only the directed scenarios can show the exact per-mode enable patterns, the bit positions of the mode field, and the fallback of reserved and crystal-less codes to idle. The same holds for the exact halted length of start-up count plus four, and for the choice between the two wake pulses when a reset request arrives at different points of the sequence.

// File: rtl/slp_pkg.sv
package slp_pkg;
  typedef enum logic [2:0] {
    ST_RUN     = 3'd0,
    ST_SLEEP   = 3'd1,
    ST_STARTUP = 3'd2,
    ST_HALT    = 3'd3,
    ST_WAKE    = 3'd4
  } seq_st_t;

  typedef enum logic [2:0] {
    MD_IDLE    = 3'b000,
    MD_ADCQ    = 3'b001,
    MD_DEEP    = 3'b010,
    MD_TIMER   = 3'b011,
    MD_RSV0    = 3'b100,
    MD_RSV1    = 3'b101,
    MD_STBY    = 3'b110,
    MD_STBY_TM = 3'b111
  } sleep_md_t;

  typedef struct packed {
    logic cpu;
    logic io;
    logic adc;
    logic asy;
    logic osc;
  } gate_t;

  localparam gate_t GATES_ALL_ON = '{cpu: 1'b1, io: 1'b1, adc: 1'b1, asy: 1'b1, osc: 1'b1};
  localparam int    HALT_CYC     = 4;
endpackage

// File: rtl/slp_ctrl_reg.sv
module slp_ctrl_reg #(
  parameter int REG_W   = 8,
  parameter int SE_BIT  = 5,
  parameter int SM2_BIT = 2,
  parameter int SM1_BIT = 4,
  parameter int SM0_BIT = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [REG_W-1:0] wdata,
  output logic [REG_W-1:0] rdata,
  output logic             sleep_en,
  output logic [2:0]       mode_raw
);
  logic [REG_W-1:0] ctrl_q;

  always_ff @(posedge clk) begin
    if (rst)     ctrl_q <= '0;
    else if (we) ctrl_q <= wdata;
  end

  assign rdata    = ctrl_q;
  assign sleep_en = ctrl_q[SE_BIT];
  assign mode_raw = {ctrl_q[SM2_BIT], ctrl_q[SM1_BIT], ctrl_q[SM0_BIT]};

  AST_REG_CLEAR_AFTER_RST: assert property (@(posedge clk) disable iff (rst)
    ($past(rst) && !$past(we)) |-> (rdata == '0)); // R1
endmodule

// File: rtl/slp_gate_map.sv
module slp_gate_map
  import slp_pkg::*;
(
  input  logic [2:0] mode_raw,
  input  logic       xtal_sel,
  output gate_t      sleep_gates,
  output logic       use_full
);
  sleep_md_t eff_md;

  always_comb begin
    eff_md = sleep_md_t'(mode_raw);
    if (eff_md == MD_RSV0 || eff_md == MD_RSV1) eff_md = MD_IDLE;
    if ((eff_md == MD_STBY || eff_md == MD_STBY_TM) && !xtal_sel) eff_md = MD_IDLE;
  end

  always_comb begin
    sleep_gates = '0;
    use_full    = 1'b0;
    case (eff_md)
      MD_IDLE:    begin sleep_gates.io = 1'b1; sleep_gates.adc = 1'b1;
                        sleep_gates.asy = 1'b1; sleep_gates.osc = 1'b1; end
      MD_ADCQ:    begin sleep_gates.adc = 1'b1; sleep_gates.asy = 1'b1;
                        sleep_gates.osc = 1'b1; end
      MD_DEEP:    use_full = 1'b1;
      MD_TIMER:   begin sleep_gates.asy = 1'b1; use_full = 1'b1; end
      MD_STBY:    sleep_gates.osc = 1'b1;
      MD_STBY_TM: begin sleep_gates.osc = 1'b1; sleep_gates.asy = 1'b1; end
      default:    begin sleep_gates.io = 1'b1; sleep_gates.adc = 1'b1;
                        sleep_gates.asy = 1'b1; sleep_gates.osc = 1'b1; end
    endcase
  end
endmodule

// File: rtl/slp_seq.sv
module slp_seq
  import slp_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sleep_go,
  input  logic             irq,
  input  logic             rst_req,
  input  gate_t            sel_gates,
  input  logic             sel_full,
  input  logic [CNT_W-1:0] cnt_short,
  input  logic [CNT_W-1:0] cnt_full,
  output logic             core_halt,
  output gate_t            gates_o,
  output logic             wake_irq,
  output logic             wake_reset
);
  localparam int HC_W = $clog2(HALT_CYC);
  localparam logic [HC_W-1:0] HC_LAST = HC_W'(HALT_CYC - 1);

  seq_st_t          state, state_n;
  logic [CNT_W-1:0] cnt, cnt_n, ld_val;
  logic [HC_W-1:0]  hcnt, hcnt_n;
  logic             rflag, rflag_n;
  gate_t            gq, gq_n;
  logic             fq, fq_n;

  assign ld_val = fq ? cnt_full : cnt_short;

  always_comb begin
    state_n = state;
    cnt_n   = cnt;
    hcnt_n  = hcnt;
    rflag_n = rflag;
    gq_n    = gq;
    fq_n    = fq;
    case (state)
      ST_RUN: if (sleep_go) begin
        state_n = ST_SLEEP;
        gq_n    = sel_gates;
        fq_n    = sel_full;
      end
      ST_SLEEP: if (rst_req || irq) begin
        rflag_n = rst_req;
        if (ld_val == '0) begin
          state_n = ST_HALT;
          hcnt_n  = HC_LAST;
        end else begin
          state_n = ST_STARTUP;
          cnt_n   = ld_val - 1'b1;
        end
      end
      ST_STARTUP: begin
        rflag_n = rflag | rst_req;
        if (cnt == '0) begin
          state_n = ST_HALT;
          hcnt_n  = HC_LAST;
        end else begin
          cnt_n = cnt - 1'b1;
        end
      end
      ST_HALT: begin
        rflag_n = rflag | rst_req;
        if (hcnt == '0) state_n = ST_WAKE;
        else            hcnt_n  = hcnt - 1'b1;
      end
      default: state_n = ST_RUN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_RUN;
      cnt        <= '0;
      hcnt       <= '0;
      rflag      <= 1'b0;
      gq         <= GATES_ALL_ON;
      fq         <= 1'b0;
      core_halt  <= 1'b0;
      gates_o    <= GATES_ALL_ON;
      wake_irq   <= 1'b0;
      wake_reset <= 1'b0;
    end else begin
      state      <= state_n;
      cnt        <= cnt_n;
      hcnt       <= hcnt_n;
      rflag      <= rflag_n;
      gq         <= gq_n;
      fq         <= fq_n;
      wake_irq   <= 1'b0;
      wake_reset <= 1'b0;
      case (state_n)
        ST_SLEEP: begin
          core_halt <= 1'b1;
          gates_o   <= gq_n;
        end
        ST_STARTUP: begin
          core_halt   <= 1'b1;
          gates_o     <= gq_n;
          gates_o.osc <= 1'b1;
        end
        ST_HALT: begin
          core_halt   <= 1'b1;
          gates_o     <= GATES_ALL_ON;
          gates_o.cpu <= 1'b0;
        end
        ST_WAKE: begin
          core_halt  <= 1'b0;
          gates_o    <= GATES_ALL_ON;
          wake_irq   <= !rflag_n;
          wake_reset <= rflag_n;
        end
        default: begin
          core_halt <= 1'b0;
          gates_o   <= GATES_ALL_ON;
        end
      endcase
    end
  end

  AST_WAKE_PULSE_EXCL: assert property (@(posedge clk) disable iff (rst)
    $onehot0({wake_irq, wake_reset})); // R10
  AST_WAKE_IRQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    wake_irq |=> !wake_irq); // R7
  AST_WAKE_RST_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    wake_reset |=> !wake_reset); // R9
  AST_WAKE_AFTER_HALT: assert property (@(posedge clk) disable iff (rst)
    (wake_irq || wake_reset) |-> ($past(core_halt) && !core_halt)); // R7
  AST_HALT_CPU_OFF: assert property (@(posedge clk) disable iff (rst)
    core_halt |-> !gates_o.cpu); // R4
  AST_RUN_ALL_ON: assert property (@(posedge clk) disable iff (rst)
    !core_halt |-> (gates_o == GATES_ALL_ON)); // R11
  AST_STARTUP_OSC_ON: assert property (@(posedge clk) disable iff (rst)
    (state == ST_STARTUP) |-> (gates_o.osc && core_halt)); // R12
endmodule

// File: rtl/slp_pwr_ctrl.sv
module slp_pwr_ctrl
  import slp_pkg::*;
#(
  parameter int REG_W = 8,
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             reg_we,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  input  logic             sleep_strobe,
  input  logic             irq_pending,
  input  logic             rst_req,
  input  logic             xtal_sel,
  input  logic [CNT_W-1:0] startup_short,
  input  logic [CNT_W-1:0] startup_full,
  output logic             core_halt,
  output logic             clk_en_cpu,
  output logic             clk_en_io,
  output logic             clk_en_adc,
  output logic             clk_en_async,
  output logic             osc_en,
  output logic             wake_irq,
  output logic             wake_reset
);
  logic       sleep_en;
  logic [2:0] mode_raw;
  gate_t      sel_gates, gates;
  logic       sel_full;

  slp_ctrl_reg #(.REG_W(REG_W)) u_reg (
    .clk(clk), .rst(rst), .we(reg_we), .wdata(reg_wdata),
    .rdata(reg_rdata), .sleep_en(sleep_en), .mode_raw(mode_raw)
  );

  slp_gate_map u_map (
    .mode_raw(mode_raw), .xtal_sel(xtal_sel),
    .sleep_gates(sel_gates), .use_full(sel_full)
  );

  slp_seq #(.CNT_W(CNT_W)) u_seq (
    .clk(clk), .rst(rst), .sleep_go(sleep_strobe && sleep_en),
    .irq(irq_pending), .rst_req(rst_req),
    .sel_gates(sel_gates), .sel_full(sel_full),
    .cnt_short(startup_short), .cnt_full(startup_full),
    .core_halt(core_halt), .gates_o(gates),
    .wake_irq(wake_irq), .wake_reset(wake_reset)
  );

  assign clk_en_cpu   = gates.cpu;
  assign clk_en_io    = gates.io;
  assign clk_en_adc   = gates.adc;
  assign clk_en_async = gates.asy;
  assign osc_en       = gates.osc;

  AST_NO_SLEEP_WITHOUT_SE: assert property (@(posedge clk) disable iff (rst)
    (!core_halt && !wake_irq && !wake_reset && sleep_strobe && !sleep_en) |=> !core_halt); // R2
endmodule

// File: tb/slp_pwr_ctrl_test.sv
module slp_pwr_ctrl_test;
  localparam int SHORT_N = 3;
  localparam int FULL_N  = 9;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       reg_we = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       sleep_strobe = 1'b0, irq_pending = 1'b0, rst_req = 1'b0, xtal_sel = 1'b1;
  logic [7:0] startup_short = 8'(SHORT_N), startup_full = 8'(FULL_N);
  logic       core_halt, clk_en_cpu, clk_en_io, clk_en_adc, clk_en_async, osc_en;
  logic       wake_irq, wake_reset;
  int         total = 0, bad = 0;
  bit         done = 1'b0;

  always #5 clk = ~clk;

  slp_pwr_ctrl uut (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .sleep_strobe(sleep_strobe), .irq_pending(irq_pending), .rst_req(rst_req),
    .xtal_sel(xtal_sel), .startup_short(startup_short), .startup_full(startup_full),
    .core_halt(core_halt), .clk_en_cpu(clk_en_cpu), .clk_en_io(clk_en_io),
    .clk_en_adc(clk_en_adc), .clk_en_async(clk_en_async), .osc_en(osc_en),
    .wake_irq(wake_irq), .wake_reset(wake_reset)
  );

  function automatic logic [4:0] gates_now();
    return {clk_en_cpu, clk_en_io, clk_en_adc, clk_en_async, osc_en};
  endfunction

  function automatic int eff_mode(int m, bit x);
    if (m == 4 || m == 5) return 0;
    if ((m == 6 || m == 7) && !x) return 0;
    return m;
  endfunction

  function automatic logic [4:0] exp_gates(int em);
    case (em)
      0: return 5'b01111;
      1: return 5'b00111;
      2: return 5'b00000;
      3: return 5'b00010;
      6: return 5'b00001;
      default: return 5'b00011;
    endcase
  endfunction

  function automatic logic [7:0] ctrl_word(bit se, int m);
    logic [2:0] mm = 3'(m);
    return (8'(se) << 5) | (8'(mm[1]) << 4) | (8'(mm[0]) << 3) | (8'(mm[2]) << 2);
  endfunction

  task automatic check(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] d);
    @(negedge clk); reg_we = 1'b1; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic strobe();
    @(negedge clk); sleep_strobe = 1'b1;
    @(negedge clk); sleep_strobe = 1'b0;
  endtask

  task automatic count_halt(output int n);
    n = 0;
    while (core_halt && n < 100) begin n++; @(negedge clk); end
  endtask

  task automatic t_reset();
    check("R1 reset value", reg_rdata, 0);
    check("R11 reset halt", core_halt, 0);
    check("R11 reset gates", gates_now(), 5'b11111);
  endtask

  task automatic t_reg_rw();
    wr(8'hA5); check("R1 readback A5", reg_rdata, 8'hA5);
    wr(8'h5A); check("R1 readback 5A", reg_rdata, 8'h5A);
    wr(8'h00); check("R1 readback 00", reg_rdata, 8'h00);
  endtask

  task automatic t_no_se();
    wr(ctrl_word(1'b0, 2));
    strobe();
    check("R2 no halt", core_halt, 0);
    check("R2 gates on", gates_now(), 5'b11111);
    @(negedge clk);
    check("R2 still no halt", core_halt, 0);
  endtask

  task automatic t_mode(int m, bit x);
    int em, n, expn;
    xtal_sel = x;
    em   = eff_mode(m, x);
    expn = ((em == 2 || em == 3) ? FULL_N : SHORT_N) + 4;
    wr(ctrl_word(1'b1, m));
    strobe();
    check($sformatf("R3 R4 R5 R6 halt m=%0d x=%0d", m, x), core_halt, 1);
    check($sformatf("R3 R4 R5 R6 gates m=%0d x=%0d", m, x), gates_now(), exp_gates(em));
    @(negedge clk); irq_pending = 1'b1;
    @(posedge clk);
    @(negedge clk); irq_pending = 1'b0;
    check($sformatf("R12 osc/cpu m=%0d", m), {osc_en, clk_en_cpu}, 2'b10);
    count_halt(n);
    check($sformatf("R7 R8 halted cycles m=%0d x=%0d", m, x), n, expn);
    check("R7 wake_irq", wake_irq, 1);
    check("R10 no wake_reset", wake_reset, 0);
    check("R11 gates on at wake", gates_now(), 5'b11111);
    @(negedge clk);
    check("R7 wake_irq one cycle", wake_irq, 0);
    check("R11 running", {core_halt, gates_now()}, 6'b011111);
    xtal_sel = 1'b1;
  endtask

  task automatic t_rst_wake();
    int n;
    wr(ctrl_word(1'b1, 2));
    strobe();
    @(negedge clk); irq_pending = 1'b1; rst_req = 1'b1;
    @(posedge clk);
    @(negedge clk); irq_pending = 1'b0; rst_req = 1'b0;
    count_halt(n);
    check("R9 halted cycles", n, FULL_N + 4);
    check("R9 wake_reset", wake_reset, 1);
    check("R9 no wake_irq", wake_irq, 0);
  endtask

  task automatic t_rst_in_startup();
    int n;
    wr(ctrl_word(1'b1, 3));
    strobe();
    @(negedge clk); irq_pending = 1'b1;
    @(posedge clk);
    @(negedge clk); irq_pending = 1'b0;
    @(negedge clk); rst_req = 1'b1;
    @(negedge clk); rst_req = 1'b0;
    count_halt(n);
    check("R9 late reset halted", n, FULL_N + 4 - 2);
    check("R9 late wake_reset", wake_reset, 1);
    check("R9 late no wake_irq", wake_irq, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_reg_rw();
    t_no_se();
    for (int m = 0; m < 8; m++) t_mode(m, 1'b1);
    t_mode(6, 1'b0);
    t_mode(7, 1'b0);
    t_rst_wake();
    t_rst_in_startup();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule